// File: doc/BRIEF.md
# Ling Pseudo-Carry Adder

A purely combinational adder of parameterised width (a multiple of three) that adds two unsigned operands and a carry-in. It produces a sum of the operand width and a carry-out.

Inside, it never forms the true carry chain. Each bit first yields a generate term (AND), a transmit term (OR) and a half-sum term (XOR). A pseudo-carry is then carried from one three-bit group to the next. In the pseudo-carry, the transmit factor of the bit below has been taken out of the ordinary carry expression. Each sum bit is rebuilt from its pseudo-carry, its half-sum and the transmit term of the bit below. The carry-out applies the one missing transmit factor to the top pseudo-carry.

The block sits in a datapath wherever a flat-delay adder is wanted. Results follow the inputs with no register on the way.

Top module: `ling_adder`

## Requirements
- R1: The value {cout, sum}, taken as a WIDTH+1 bit number, equals x + y + cin for every operand pair and carry-in.
- R2: Bit 0 of sum equals x[0] XOR y[0] XOR cin.
- R3: With one operand all ones, the carry is carried through every group: all-ones + 0 with cin=1, and all-ones + 1 with cin=0, both give sum 0 and cout 1.
- R4: cout is 1 exactly when x + y + cin is at least 2 to the power WIDTH. All-ones + 0 with cin=0 gives cout 0.
- R5: For every bit i from 1 to WIDTH-1, the carry entering bit i (recovered at the ports as sum[i] XOR x[i] XOR y[i]) is 1 exactly when x[i-1:0] + y[i-1:0] + cin is at least 2 to the power i. This includes the bits at group boundaries 3, 6, 9 and so on.
- R6: With both operands zero, the result is sum 0 and cout 0 when cin=0, and sum 1 and cout 0 when cin=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | First operand, unsigned |
| y | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of x + y + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
A wrong pseudo-carry in a group corrupts that group's sum bits at once. It also corrupts every higher group whose transmit terms are all ones, so the damage shows on the ports in the same cycle the operands are applied. The bench recovers the carry into each bit from sum, x and y, and compares it with a per-bit reference. This finds which bit and which group boundary went wrong, not only that the total is off. Long propagate runs (all-ones operands) and isolated generates just below a group boundary are used to reach the cross-group recurrence.

// File: rtl/ling_pkg.sv
package ling_pkg;

    localparam int GRP_BITS = 3;

    // Pseudo-carries for the three positions above a group base b.
    // g/t are the group's generate/transmit bits; tin is the transmit bit
    // just below the base (1 for the lowest group); hin is h at the base.
    function automatic logic [2:0] grp_pseudo(
        input logic [2:0] g,
        input logic [2:0] t,
        input logic       tin,
        input logic       hin
    );
        logic [2:0] r;
        r[0] = g[0] | (tin & hin);
        r[1] = g[1] | g[0] | (t[0] & tin & hin);
        r[2] = g[2] | g[1] | (t[1] & g[0]) | (t[1] & t[0] & tin & hin);
        return r;
    endfunction

endpackage

// File: rtl/ling_terms.sv
module ling_terms #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] xmit,
    output logic [WIDTH-1:0] half
);
    typedef struct packed {
        logic [WIDTH-1:0] gen;
        logic [WIDTH-1:0] xmit;
        logic [WIDTH-1:0] half;
    } terms_t;

    terms_t terms_d;

    always_comb begin
        terms_d.gen  = a & b;
        terms_d.xmit = a | b;
        terms_d.half = a ^ b;
    end

    assign gen  = terms_d.gen;
    assign xmit = terms_d.xmit;
    assign half = terms_d.half;
endmodule

// File: rtl/ling_hchain.sv
module ling_hchain #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] xmit,
    input  logic             cin,
    output logic [WIDTH:0]   hp
);
    import ling_pkg::*;

    localparam int NGRP = WIDTH / GRP_BITS;

    logic [WIDTH:0] hp_d;

    assign hp_d[0] = cin;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam int BASE = k * GRP_BITS;
        if (k == 0) begin : g_low
            assign hp_d[BASE+3:BASE+1] =
                grp_pseudo(gen[BASE+:3], xmit[BASE+:3], 1'b1, hp_d[BASE]);
        end else begin : g_up
            assign hp_d[BASE+3:BASE+1] =
                grp_pseudo(gen[BASE+:3], xmit[BASE+:3], xmit[BASE-1], hp_d[BASE]);
        end
    end

    assign hp = hp_d;
endmodule

// File: rtl/ling_sumgen.sv
module ling_sumgen #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH:0]   hp,
    input  logic [WIDTH-1:0] xmit,
    input  logic [WIDTH-1:0] half,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             co
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             co;
    } out_t;

    out_t out_d;

    always_comb begin
        out_d.res[0] = half[0] ^ cin;
        for (int i = 1; i < WIDTH; i++) begin
            out_d.res[i] = (~hp[i] & half[i]) | (hp[i] & (half[i] ^ xmit[i-1]));
        end
        out_d.co = hp[WIDTH] & xmit[WIDTH-1];
    end

    assign res = out_d.res;
    assign co  = out_d.co;
endmodule

// File: rtl/ling_adder.sv
module ling_adder #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] g_w;
    logic [WIDTH-1:0] t_w;
    logic [WIDTH-1:0] p_w;
    logic [WIDTH:0]   h_w;
    logic [WIDTH-1:0] sum_w;
    logic             cout_w;

    ling_terms #(.WIDTH(WIDTH)) u_terms (
        .a    (x),
        .b    (y),
        .gen  (g_w),
        .xmit (t_w),
        .half (p_w)
    );

    ling_hchain #(.WIDTH(WIDTH)) u_chain (
        .gen  (g_w),
        .xmit (t_w),
        .cin  (cin),
        .hp   (h_w)
    );

    ling_sumgen #(.WIDTH(WIDTH)) u_sum (
        .hp   (h_w),
        .xmit (t_w),
        .half (p_w),
        .cin  (cin),
        .res  (sum_w),
        .co   (cout_w)
    );

    assign sum  = sum_w;
    assign cout = cout_w;
endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
    parameter int WIDTH = 24
) (
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [WIDTH:0]   h,
    input logic [WIDTH-1:0] t
);
    logic [WIDTH:0] total_w;
    assign total_w = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        if (!$isunknown({x, y, cin})) begin
            // R1
            a_r1_total: assert ({cout, sum} == total_w);
            // R2
            a_r2_bit0: assert (sum[0] == (x[0] ^ y[0] ^ cin));
            // R4
            a_r4_cout: assert (cout == (h[WIDTH] & t[WIDTH-1]));
            // R5: chain base and per-bit carry recovery from the pseudo-carry
            a_r5_hbase: assert (h[0] == cin);
            for (int i = 1; i < WIDTH; i++) begin
                a_r5_carry_recover: assert ((sum[i] ^ x[i] ^ y[i]) == (h[i] & t[i-1]));
            end
        end
    end
endmodule

bind ling_adder ling_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .x    (x),
    .y    (y),
    .cin  (cin),
    .sum  (sum),
    .cout (cout),
    .h    (h_w),
    .t    (t_w)
);

// File: tb/tb_ling_adder.sv
module tb_ling_adder;
    localparam int WIDTH = 24;
    localparam int MAXCYC = 100000;

    typedef struct {
        logic [WIDTH-1:0] x;
        logic [WIDTH-1:0] y;
        logic             cin;
        logic [WIDTH:0]   exp_total;
        logic [WIDTH-1:0] exp_carry;
        string            tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WIDTH-1:0] x = '0;
    logic [WIDTH-1:0] y = '0;
    logic cin = 1'b0;
    logic [WIDTH-1:0] sum;
    logic cout;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    item_t q[$];

    ling_adder #(.WIDTH(WIDTH)) dut (
        .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout)
    );

    always #10 clk = ~clk;

    function automatic logic [WIDTH-1:0] ref_carries(
        input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input logic c0);
        logic [WIDTH-1:0] cv;
        for (int i = 0; i < WIDTH; i++) begin
            logic [WIDTH:0] part;
            logic [WIDTH:0] lim;
            part = '0;
            for (int j = 0; j < i; j++) begin
                part[j] = a[j];
            end
            lim = '0;
            for (int j = 0; j < i; j++) begin
                lim[j] = b[j];
            end
            part = part + lim + {{WIDTH{1'b0}}, c0};
            cv[i] = (i == 0) ? c0 : part[i];
        end
        return cv;
    endfunction

    task automatic check(input bit ok, input string what, input string tag,
                         input logic [WIDTH:0] act, input logic [WIDTH:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic c, input string tag);
        item_t it;
        @(negedge clk);
        x   = a;
        y   = b;
        cin = c;
        it.x = a;
        it.y = b;
        it.cin = c;
        it.exp_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c};
        it.exp_carry = ref_carries(a, b, c);
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compares half a cycle after each drive
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && q.size() > 0) begin
                item_t it;
                logic [WIDTH-1:0] rc;
                it = q.pop_front();
                check({cout, sum} == it.exp_total, "total", it.tag,
                      {cout, sum}, it.exp_total);
                check(cout == it.exp_total[WIDTH], "cout R4", it.tag,
                      {{WIDTH{1'b0}}, cout}, {{WIDTH{1'b0}}, it.exp_total[WIDTH]});
                check(sum[0] == (it.x[0] ^ it.y[0] ^ it.cin), "bit0 R2", it.tag,
                      {{WIDTH{1'b0}}, sum[0]}, {{WIDTH{1'b0}}, it.x[0] ^ it.y[0] ^ it.cin});
                rc = sum ^ it.x ^ it.y;
                rc[0] = it.cin;
                check(rc == it.exp_carry, "carries R5", it.tag,
                      {1'b0, rc}, {1'b0, it.exp_carry});
            end
        end
    end

    initial begin
        repeat (MAXCYC) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [WIDTH-1:0] ones;
        ones = '1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: zero inputs give zero outputs (R6)
        @(negedge clk);
        check({cout, sum} == '0, "reset outputs R6", "R6", {cout, sum}, '0);
        drive('0, '0, 1'b0, "R6 zero+zero");
        drive('0, '0, 1'b1, "R6 zero+cin");
        drive(ones, '0, 1'b1, "R3 ones+cin");
        drive(ones, {{(WIDTH-1){1'b0}}, 1'b1}, 1'b0, "R3 ones+one");
        drive('0, ones, 1'b1, "R3 swapped ones+cin");
        drive(ones, '0, 1'b0, "R4 ones no carry");
        drive(ones, ones, 1'b1, "R4 ones+ones+cin");
        // generate just below each group boundary, propagate above it (R5)
        for (int k = 1; k < WIDTH / 3; k++) begin
            logic [WIDTH-1:0] a;
            logic [WIDTH-1:0] b;
            a = '0;
            b = '0;
            a[3*k-1] = 1'b1;
            b[3*k-1] = 1'b1;
            for (int j = 3 * k; j < WIDTH; j++) begin
                a[j] = 1'b1;
            end
            drive(a, b, 1'b0, "R5 boundary generate");
            b[3*k-1] = 1'b0;
            drive(a, b, 1'b1, "R5 boundary kill");
        end
        // cin alone with propagate runs of every length (R2, R5)
        for (int n = 0; n <= WIDTH; n++) begin
            logic [WIDTH-1:0] a;
            a = '0;
            for (int j = 0; j < n; j++) begin
                a[j] = 1'b1;
            end
            drive(a, '0, 1'b1, "R2 propagate run");
        end
        for (int r = 0; r < 300; r++) begin
            drive(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), "R1 random");
        end
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule